// File: doc/BRIEF.md
# Phase Discriminator with Delta-Phase Output

This block takes a stream of 18-bit phase words, each qualified by a valid strobe. It first shifts every word left by zero to three bit positions and drops whatever leaves the top. This folds the phase circle onto itself, so that the result is modulo 360, 180, 90 or 45 degrees and phase-shift-keyed modulation disappears from it. The folded phase is then either passed out as it is, or differenced against the folded phase of an earlier valid sample to give a frequency estimate (dphi/dt). The lag of that difference is one to eight samples. The difference is produced inside the block and needs no outside feedback path.

Three static configuration inputs control it: the shift amount, a three-bit lag code and a one-bit output select. The output is registered one clock after the input strobe. A separate flag tells the consumer whether enough history has been collected for the difference to mean anything.

Top module: `pd_discriminator`

## Requirements
- R1: The folded phase equals `in_phase` shifted left by `cfg_shift` (0 to 3) positions and truncated to its low 18 bits. For example, 0x12345 with a shift of 2 gives 0x08D14, and 0x20000 with a shift of 1 gives 0.
- R2: When `cfg_sel_dphi` is 0, `out_data` is the folded phase of the sample accepted on the previous clock.
- R3: When `cfg_sel_dphi` is 1, `out_data` is the folded phase of the current sample minus the folded phase of an earlier valid sample.
- R4: In the R3 difference, lag code k (`cfg_delay`, 0 to 7) selects the sample accepted k+1 valid samples earlier. Code 0 gives a lag of 1 and code 7 gives a lag of 8.
- R5: The history advances only on cycles with `in_valid` high. Idle cycles between samples do not change which sample a difference uses.
- R6: The difference is taken modulo 2^18. For example, 0x00005 after 0x3FFFE gives 0x00007, and 0x3FFFE after 0x00005 gives 0x3FFF9.
- R7: `out_valid` equals `in_valid` one clock later. While `out_valid` is low, `out_data` holds its last value.
- R8: `out_dphi_ok` is high only with `out_valid`. It is high only once at least k+1 valid samples have been accepted, counting the current one's predecessors, since reset or since the last change of `cfg_delay`. The flag reflects this count whatever `cfg_sel_dphi` is set to.
- R9: During reset and immediately after it, `out_valid`, `out_dphi_ok` and `out_data` are 0, and the sample history counts as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_phase | input | 18 | Input phase word (full circle = 2^18) |
| cfg_shift | input | 2 | Fold shift, 0 to 3 bit positions |
| cfg_delay | input | 3 | Lag code; lag = code + 1 valid samples |
| cfg_sel_dphi | input | 1 | 1 = difference output, 0 = folded phase output |
| out_valid | output | 1 | Output strobe, one clock after input |
| out_data | output | 18 | Folded phase or phase difference |
| out_dphi_ok | output | 1 | Difference history is filled for the current lag |

## Verification
Phase mode is driven from a vector table that covers every shift amount, including words whose top bits must be dropped, so a wrong shift or a missing truncation shows up directly. Difference mode is tried with a linear ramp at the shortest lag, where every difference is the same constant, and with a quadratic sequence at the longest lag, where a lag that is off by one gives a different value. It is also tried with idle gaps between samples, which tell apart a history that advances per clock from one that advances per sample, and with pairs that cross the zero point of the phase circle, which expose non-modular subtraction. A change of lag code in mid-stream and a reset in mid-run check that the ok flag returns to 0 and then comes back on the correct sample.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int PD_PHASE_W = 18;
    localparam int PD_DEPTH   = 8;
    localparam int PD_SHIFT_W = 2;

    typedef enum logic {
        SEL_PHASE = 1'b0,
        SEL_DPHI  = 1'b1
    } out_sel_e;
endpackage

// File: rtl/pd_shifter.sv
module pd_shifter #(
    parameter int PHASE_W = pd_pkg::PD_PHASE_W,
    parameter int SHIFT_W = pd_pkg::PD_SHIFT_W
) (
    input  logic [PHASE_W-1:0] din,
    input  logic [SHIFT_W-1:0] amount,
    output logic [PHASE_W-1:0] dout
);
    localparam int NCAND = 2 ** SHIFT_W;

    logic [PHASE_W-1:0] cand [NCAND];

    // one candidate per fold amount; bits pushed off the top are lost (R1)
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        assign cand[k] = din << k;
    end

    assign dout = cand[amount];
endmodule

// File: rtl/pd_delay_line.sv
module pd_delay_line #(
    parameter int PHASE_W = pd_pkg::PD_PHASE_W,
    parameter int DEPTH   = pd_pkg::PD_DEPTH,
    localparam int CODE_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [PHASE_W-1:0] din,
    input  logic [CODE_W-1:0]  tap_sel,
    output logic [PHASE_W-1:0] tap_out
);
    typedef struct packed {
        logic [DEPTH-1:0][PHASE_W-1:0] taps;
    } dl_state_t;

    dl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.taps[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.taps[i] = st_q.taps[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // taps[0] is the previous accepted sample, so code k reaches k+1 back (R4)
    assign tap_out = st_q.taps[tap_sel];

    a_r5_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(st_q.taps));
    a_r4_newest_tap: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> st_q.taps[0] == $past(din));
endmodule

// File: rtl/pd_fill_tracker.sv
module pd_fill_tracker #(
    parameter int DEPTH   = pd_pkg::PD_DEPTH,
    localparam int CODE_W = $clog2(DEPTH),
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CODE_W-1:0] delay_code,
    output logic              lag_ok
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [FILL_W-1:0] fill;
    } ft_state_t;

    ft_state_t         st_d, st_q;
    logic [FILL_W-1:0] fill_eff;

    always_comb begin
        st_d      = st_q;
        st_d.code = delay_code;
        // a new lag code discards the history count (R8)
        fill_eff  = (delay_code != st_q.code) ? '0 : st_q.fill;
        lag_ok    = push && (fill_eff > FILL_W'(delay_code));
        st_d.fill = fill_eff;
        if (push && fill_eff != FILL_W'(DEPTH)) begin
            st_d.fill = fill_eff + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= FILL_W'(DEPTH));
    a_r5_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && delay_code == st_q.code) |=> $stable(st_q.fill));
endmodule

// File: rtl/pd_discriminator.sv
module pd_discriminator #(
    parameter int PHASE_W = pd_pkg::PD_PHASE_W,
    parameter int DEPTH   = pd_pkg::PD_DEPTH,
    parameter int SHIFT_W = pd_pkg::PD_SHIFT_W,
    localparam int CODE_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PHASE_W-1:0] in_phase,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [CODE_W-1:0]  cfg_delay,
    input  logic               cfg_sel_dphi,
    output logic               out_valid,
    output logic [PHASE_W-1:0] out_data,
    output logic               out_dphi_ok
);
    import pd_pkg::*;

    typedef struct packed {
        logic               valid;
        logic               ok;
        logic [PHASE_W-1:0] data;
    } out_state_t;

    out_state_t         st_d, st_q;
    logic [PHASE_W-1:0] folded;
    logic [PHASE_W-1:0] earlier;
    logic               lag_ok;

    pd_shifter #(.PHASE_W(PHASE_W), .SHIFT_W(SHIFT_W)) u_fold (
        .din    (in_phase),
        .amount (cfg_shift),
        .dout   (folded)
    );

    pd_delay_line #(.PHASE_W(PHASE_W), .DEPTH(DEPTH)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (in_valid),
        .din     (folded),
        .tap_sel (cfg_delay),
        .tap_out (earlier)
    );

    pd_fill_tracker #(.DEPTH(DEPTH)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (in_valid),
        .delay_code (cfg_delay),
        .lag_ok     (lag_ok)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.ok    = lag_ok;
        if (in_valid) begin
            // modular subtraction gives the signed wrap-safe delta (R6)
            st_d.data = (out_sel_e'(cfg_sel_dphi) == SEL_DPHI) ? folded - earlier : folded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_dphi_ok = st_q.ok;
    assign out_data    = st_q.data;

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    a_r8_ok_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_dphi_ok |-> out_valid);
    a_r8_code_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_delay != $past(cfg_delay)) |=> !out_dphi_ok);
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_sel_dphi && cfg_shift == '0) |=> out_data == $past(in_phase));
endmodule

// File: tb/tb_pd_discriminator.sv
`timescale 1ns/1ps
module tb_pd_discriminator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_phase = '0;
    logic [1:0]  cfg_shift = '0;
    logic [2:0]  cfg_delay = '0;
    logic        cfg_sel_dphi = 1'b0;
    logic        out_valid;
    logic [17:0] out_data;
    logic        out_dphi_ok;

    always #10 clk = ~clk;

    pd_discriminator dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
        .cfg_shift(cfg_shift), .cfg_delay(cfg_delay), .cfg_sel_dphi(cfg_sel_dphi),
        .out_valid(out_valid), .out_data(out_data), .out_dphi_ok(out_dphi_ok)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference history built from the requirements
    logic [17:0] m_hist [8];
    int          m_fill = 0;
    int          m_code = 0;
    logic [17:0] last_out = '0;

    // table: [37:20] phase, [19:18] shift, [17:0] expected folded phase (R1)
    localparam logic [37:0] VEC [8] = '{
        {18'h12345, 2'd0, 18'h12345},
        {18'h12345, 2'd1, 18'h2468A},
        {18'h12345, 2'd2, 18'h08D14},
        {18'h12345, 2'd3, 18'h11A28},
        {18'h3FFFF, 2'd3, 18'h3FFF8},
        {18'h20000, 2'd1, 18'h00000},
        {18'h0F0F0, 2'd2, 18'h3C3C0},
        {18'h00001, 2'd3, 18'h00008}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_hist[i] = '0;
        m_fill = 0;
        m_code = 0;
    endtask

    task automatic send(input logic [17:0] ph, input logic [1:0] sh, input logic [2:0] code,
                        input bit sel, input string req, output logic [17:0] got);
        logic [17:0] s;
        logic [17:0] diff;
        bit          exp_ok;
        @(negedge clk);
        in_valid = 1'b1; in_phase = ph; cfg_shift = sh; cfg_delay = code; cfg_sel_dphi = sel;
        s = ph << sh;
        if (int'(code) != m_code) m_fill = 0;
        m_code = int'(code);
        exp_ok = (m_fill > int'(code));
        diff   = s - m_hist[code];
        for (int i = 7; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = s;
        if (m_fill < 8) m_fill++;
        @(posedge clk);
        #1;
        chk({req, " R7 out_valid"}, 32'(out_valid), 32'd1);
        chk({req, " R8 ok flag"}, 32'(out_dphi_ok), 32'(exp_ok));
        if (!sel) chk({req, " R2 phase"}, 32'(out_data), 32'(s));
        else if (exp_ok) chk({req, " R3 diff"}, 32'(out_data), 32'(diff));
        got = out_data;
        last_out = out_data;
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk({req, " R7 idle valid"}, 32'(out_valid), 32'd0);
        chk({req, " R7 idle hold"}, 32'(out_data), 32'(last_out));
        chk({req, " R8 idle ok"}, 32'(out_dphi_ok), 32'd0);
    endtask

    initial begin
        logic [17:0] g;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset valid", 32'(out_valid), 32'd0);
        chk("R9 reset ok", 32'(out_dphi_ok), 32'd0);
        chk("R9 reset data", 32'(out_data), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 after reset valid", 32'(out_valid), 32'd0);

        // R1 / R2: table walk in phase mode
        for (int i = 0; i < 8; i++) begin
            send(VEC[i][37:20], VEC[i][19:18], 3'd0, 1'b0, "R1 table", g);
            chk("R1 folded value", 32'(g), 32'(VEC[i][17:0]));
        end

        // R3 / R4: ramp at lag 1, step 5 each sample
        for (int i = 0; i < 6; i++) begin
            send(18'(100 + 5 * i), 2'd0, 3'd0, 1'b1, "R4 lag1 ramp", g);
            if (i > 0) chk("R3 ramp step", 32'(g), 32'd5);
        end

        // R4 / R8: quadratic at lag 8 (code 7 resets history count)
        for (int i = 0; i < 12; i++) begin
            send(18'(3 * i * i), 2'd0, 3'd7, 1'b1, "R4 lag8 quad", g);
            if (i >= 8) chk("R4 lag8 value", 32'(g), 32'(18'(3 * i * i - 3 * (i - 8) * (i - 8))));
        end

        // R5: idle gaps with lag code 2
        for (int i = 0; i < 8; i++) begin
            send(18'(7 * i + 1000), 2'd0, 3'd2, 1'b1, "R5 gaps", g);
            if (i >= 3) chk("R5 gap diff", 32'(g), 32'd21);
            idle("R5 gap");
            if (i % 2 == 0) idle("R5 gap2");
        end

        // R6: wrap across zero at lag 1
        send(18'h3FFFE, 2'd0, 3'd0, 1'b1, "R6 wrap a", g);
        send(18'h00005, 2'd0, 3'd0, 1'b1, "R6 wrap b", g);
        chk("R6 forward wrap", 32'(g), 32'h00007);
        send(18'h3FFFE, 2'd0, 3'd0, 1'b1, "R6 wrap c", g);
        chk("R6 backward wrap", 32'(g), 32'h3FFF9);

        // R8: lag code change mid stream (0 -> 3), in phase mode too
        for (int i = 0; i < 3; i++) send(18'(50 * i), 2'd0, 3'd0, 1'b0, "R8 pre", g);
        for (int i = 0; i < 6; i++) send(18'(50 * i + 9), 2'd0, 3'd3, 1'b1, "R8 post change", g);

        // R1 + R3: fold before difference
        send(18'h10000, 2'd2, 3'd0, 1'b1, "R1 fold dphi a", g);
        send(18'h10001, 2'd2, 3'd0, 1'b1, "R1 fold dphi b", g);
        chk("R1 folded diff", 32'(g), 32'd4);

        // R9: reset mid-run clears history
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 midrun valid", 32'(out_valid), 32'd0);
        chk("R9 midrun data", 32'(out_data), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        last_out = '0;
        for (int i = 0; i < 3; i++) send(18'(11 * i), 2'd0, 3'd1, 1'b1, "R9 refill", g);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule